// File: doc/BRIEF.md
# I2C SCL and Condition Timing Generator

This block turns two programmed numbers, a prescaler and a bus cycle length, into every phase duration an I2C master needs. It then paces the SCL line and a set of strobes through the START, bit, repeated-start and STOP phases. The strobes are single-clock pulses that a separate bit engine uses to drive SDA at the right moments. Shifting bytes, handling ACK and FIFOs all belong to that engine, not to this block.

Two timing sets are held: one for fast mode and one for high-speed mode. A load strobe derives all fields from the current cycle length and prescaler, and writes them into the set that the mode input selects. While the block runs, the same mode input chooses which set paces the bus. The data-hold value is held once and shared by both sets. All stored values can be read back as packed 32-bit words.

Top module: `i2c_scl_timing`

## Requirements
- R1: For a cycle length C, the fields are: SCL low = SCL high = C/2 (integer division); start setup = start hold = stop setup = C/2; data setup = data hold = (C/2)/2; release = C.
- R2: Word 1 holds start setup in [31:24], start hold in [23:16] and stop setup in [15:8]. Word 2 holds data setup in [31:24], SCL low in [15:8] and SCL high in [7:0]. Word 3 holds the prescaler in [23:16] and the release time in [7:0]. The hold word holds the data hold in [7:0]. Every other bit reads 0.
- R3: A clock with `cfg_load`=1 writes the derived fields into the high-speed set when `hs_mode`=1, and into the fast set otherwise. The other set is left unchanged. The shared hold word is rewritten on every load.
- R4: One timing unit lasts (prescaler+1) clocks of the set selected by `hs_mode`. Units are counted by a free-running counter that runs from reset onward.
- R5: Each phase lasts its field value in units. A field of 0 still lasts one unit. Phase changes happen only at unit boundaries.
- R6: With `run`=1, the idle block enters start setup at the next unit boundary. The sequence then runs start setup, start hold, SCL low, and from there SCL low and SCL high alternate. `scl_o` is 0 only during the SCL low phase.
- R7: At the end of an SCL low phase, `stop_req`=1 leads to stop setup and then idle. Otherwise `rs_req`=1 leads to a release phase (release time) and then start setup. Stop takes priority over repeated start.
- R8: The start-setup, start-hold, stop and release strobes pulse for one clock, at the boundary that ends their phase. `tick_scl_rise` pulses at the end of SCL low. `tick_scl_fall` pulses at the end of start hold and at the end of SCL high.
- R9: During SCL low, `tick_data_hd` pulses at the boundary that ends unit (hold+1) of the phase. `tick_data_su` pulses at the boundary where the remaining units, counting the current one, equal data setup + 1.
- R10: After reset, all words read 0, the block is idle, `scl_o` is 1 and no strobe is active.
- R11: While idle with `run`=0, `stop_req` and `rs_req` have no effect: `scl_o` stays 1 and no strobe pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Derive fields and store them in the selected set |
| hs_mode | input | 1 | 1 selects the high-speed set, 0 the fast set |
| cfg_prescale | input | 8 | Prescaler value |
| cfg_cycle | input | 8 | Cycle length in units |
| run | input | 1 | Start a transfer from idle |
| stop_req | input | 1 | End the transfer after the current SCL low phase |
| rs_req | input | 1 | Repeated start after the current SCL low phase |
| scl_o | output | 1 | SCL level |
| tick_start_su | output | 1 | End of start setup |
| tick_start_hd | output | 1 | End of start hold |
| tick_data_su | output | 1 | Data setup point within SCL low |
| tick_data_hd | output | 1 | Data hold point within SCL low |
| tick_scl_rise | output | 1 | SCL rising boundary |
| tick_scl_fall | output | 1 | SCL falling boundary |
| tick_stop_su | output | 1 | End of stop setup |
| tick_release | output | 1 | End of repeated-start release |
| fs_word1 | output | 32 | Fast set, word 1 |
| fs_word2 | output | 32 | Fast set, word 2 |
| fs_word3 | output | 32 | Fast set, word 3 |
| hs_word1 | output | 32 | High-speed set, word 1 |
| hs_word2 | output | 32 | High-speed set, word 2 |
| hs_word3 | output | 32 | High-speed set, word 3 |
| hold_word | output | 32 | Shared data hold word |

## Verification
The bench builds the block with its default 8-bit prescaler and cycle widths. With these widths, a cycle length of 255 (the longest phases, 127 units) and a cycle length of 0 (every phase clamped to one unit) can both be reached in a short run. Prescalers of 0, 1 and 2 show units of one, two and three clocks. Each set is loaded with different values so that the pacing shows which set is in use, and both the stop path and the repeated-start path (with both requests raised together) are driven.

// File: rtl/i2c_tmg_pkg.sv
package i2c_tmg_pkg;

    localparam int FLD_W  = 8;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_SSU  = 3'd1,
        PH_SHD  = 3'd2,
        PH_LOW  = 3'd3,
        PH_HIGH = 3'd4,
        PH_STOP = 3'd5,
        PH_REL  = 3'd6
    } phase_t;

    typedef struct packed {
        logic [FLD_W-1:0] su_sta;
        logic [FLD_W-1:0] hd_sta;
        logic [FLD_W-1:0] su_sto;
        logic [FLD_W-1:0] dsu;
        logic [FLD_W-1:0] low;
        logic [FLD_W-1:0] high;
        logic [FLD_W-1:0] pre;
        logic [FLD_W-1:0] rel;
    } tset_t;

    function automatic logic [FLD_W-1:0] max1(input logic [FLD_W-1:0] v);
        return (v == '0) ? FLD_W'(1) : v;
    endfunction

    function automatic logic [WORD_W-1:0] pack_w1(input tset_t s);
        return {s.su_sta, s.hd_sta, s.su_sto, 8'h00};
    endfunction

    function automatic logic [WORD_W-1:0] pack_w2(input tset_t s);
        return {s.dsu, 8'h00, s.low, s.high};
    endfunction

    function automatic logic [WORD_W-1:0] pack_w3(input tset_t s);
        return {8'h00, s.pre, 8'h00, s.rel};
    endfunction

endpackage

// File: rtl/i2c_tmg_calc.sv
module i2c_tmg_calc
    import i2c_tmg_pkg::*;
#(
    parameter int CYC_W = 8,
    parameter int PRE_W = 8
) (
    input  logic [CYC_W-1:0] cycle_i,
    input  logic [PRE_W-1:0] pre_i,
    output tset_t            set_o,
    output logic [FLD_W-1:0] hold_o
);

    localparam int HALF_W = (CYC_W > 1) ? CYC_W - 1 : 1;

    logic [HALF_W-1:0] half;
    logic [FLD_W-1:0]  low_f;
    logic [FLD_W-1:0]  quarter_f;

    always_comb begin
        half      = HALF_W'(cycle_i >> 1);
        low_f     = FLD_W'(half);
        quarter_f = low_f >> 1;

        set_o.su_sta = low_f;
        set_o.hd_sta = low_f;
        set_o.su_sto = low_f;
        set_o.low    = low_f;
        set_o.high   = low_f;
        set_o.dsu    = quarter_f;
        set_o.rel    = FLD_W'(cycle_i);
        set_o.pre    = FLD_W'(pre_i);
        hold_o       = quarter_f;
    end

endmodule

// File: rtl/i2c_tmg_bank.sv
module i2c_tmg_bank
    import i2c_tmg_pkg::*;
#(
    parameter int NSETS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             sel_hs_i,
    input  tset_t            calc_i,
    input  logic [FLD_W-1:0] calc_hold_i,
    output tset_t            fs_o,
    output tset_t            hs_o,
    output tset_t            act_o,
    output logic [FLD_W-1:0] hold_o
);

    localparam int SEL_W = (NSETS > 1) ? $clog2(NSETS) : 1;

    tset_t sets [NSETS];
    logic [FLD_W-1:0] hold_d, hold_q;

    for (genvar gi = 0; gi < NSETS; gi++) begin : g_set
        tset_t set_d, set_q;

        always_comb begin
            set_d = set_q;
            if (load_i && (SEL_W'(sel_hs_i) == SEL_W'(gi)))
                set_d = calc_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) set_q <= '0;
            else        set_q <= set_d;
        end

        assign sets[gi] = set_q;
    end

    always_comb begin
        hold_d = load_i ? calc_hold_i : hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign fs_o   = sets[0];
    assign hs_o   = sets[NSETS-1];
    assign act_o  = sel_hs_i ? hs_o : fs_o;
    assign hold_o = hold_q;

    // R3
    fs_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && sel_hs_i) |=> $stable(fs_o));

    // R3
    hs_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !sel_hs_i) |=> $stable(hs_o));

endmodule

// File: rtl/i2c_tmg_prescale.sv
module i2c_tmg_prescale
    import i2c_tmg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLD_W-1:0] pre_i,
    output logic             unit_o
);

    logic [FLD_W-1:0] pcnt_d, pcnt_q;

    always_comb begin
        unit_o = (pcnt_q >= pre_i);
        pcnt_d = unit_o ? '0 : pcnt_q + FLD_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    // R4
    unit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_o && pre_i != '0 && $stable(pre_i)) |=> !unit_o);

endmodule

// File: rtl/i2c_tmg_seq.sv
module i2c_tmg_seq
    import i2c_tmg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_i,
    input  logic             run_i,
    input  logic             stop_req_i,
    input  logic             rs_req_i,
    input  tset_t            act_i,
    input  logic [FLD_W-1:0] hold_i,
    output logic             scl_o,
    output logic             t_ssu_o,
    output logic             t_shd_o,
    output logic             t_dsu_o,
    output logic             t_dhd_o,
    output logic             t_rise_o,
    output logic             t_fall_o,
    output logic             t_stop_o,
    output logic             t_rel_o
);

    typedef struct packed {
        phase_t           ph;
        logic [FLD_W-1:0] cnt;
    } seq_t;

    seq_t cur_d, cur_q;
    phase_t nxt_ph;
    logic [FLD_W-1:0] len_nxt;
    logic [FLD_W-1:0] len_low;
    logic last;

    function automatic logic [FLD_W-1:0] len_of(input phase_t p, input tset_t s);
        case (p)
            PH_SSU:  return max1(s.su_sta);
            PH_SHD:  return max1(s.hd_sta);
            PH_LOW:  return max1(s.low);
            PH_HIGH: return max1(s.high);
            PH_STOP: return max1(s.su_sto);
            PH_REL:  return max1(s.rel);
            default: return '0;
        endcase
    endfunction

    always_comb begin
        case (cur_q.ph)
            PH_SSU:  nxt_ph = PH_SHD;
            PH_SHD:  nxt_ph = PH_LOW;
            PH_LOW:  nxt_ph = stop_req_i ? PH_STOP : (rs_req_i ? PH_REL : PH_HIGH);
            PH_HIGH: nxt_ph = PH_LOW;
            PH_STOP: nxt_ph = PH_IDLE;
            PH_REL:  nxt_ph = PH_SSU;
            default: nxt_ph = PH_SSU;
        endcase
        len_nxt = len_of(nxt_ph, act_i);
        len_low = max1(act_i.low);
        last    = unit_i && (cur_q.ph != PH_IDLE) && (cur_q.cnt <= FLD_W'(1));

        cur_d = cur_q;
        if (unit_i) begin
            if (cur_q.ph == PH_IDLE) begin
                if (run_i) begin
                    cur_d.ph  = PH_SSU;
                    cur_d.cnt = len_of(PH_SSU, act_i);
                end
            end else if (last) begin
                cur_d.ph  = nxt_ph;
                cur_d.cnt = len_nxt;
            end else begin
                cur_d.cnt = cur_q.cnt - FLD_W'(1);
            end
        end

        scl_o    = (cur_q.ph != PH_LOW);
        t_ssu_o  = last && (cur_q.ph == PH_SSU);
        t_shd_o  = last && (cur_q.ph == PH_SHD);
        t_rise_o = last && (cur_q.ph == PH_LOW);
        t_fall_o = last && ((cur_q.ph == PH_SHD) || (cur_q.ph == PH_HIGH));
        t_stop_o = last && (cur_q.ph == PH_STOP);
        t_rel_o  = last && (cur_q.ph == PH_REL);
        t_dsu_o  = unit_i && (cur_q.ph == PH_LOW) &&
                   ({1'b0, cur_q.cnt} == ({1'b0, act_i.dsu} + 9'd1));
        t_dhd_o  = unit_i && (cur_q.ph == PH_LOW) &&
                   (({1'b0, len_low} - {1'b0, cur_q.cnt}) == {1'b0, hold_i});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{ph: PH_IDLE, cnt: '0};
        else        cur_q <= cur_d;
    end

    // R8
    scl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_rise_o |=> scl_o);

    // R8
    scl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_fall_o |=> !scl_o);

    // R7
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_stop_o |=> (cur_q.ph == PH_IDLE));

    // R5
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.ph != PH_IDLE) |-> (cur_q.cnt != '0));

    // R8
    tick_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({t_ssu_o, t_rise_o, t_fall_o, t_stop_o, t_rel_o}));

endmodule

// File: rtl/i2c_scl_timing.sv
module i2c_scl_timing
    import i2c_tmg_pkg::*;
#(
    parameter int CYC_W = 8,
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              hs_mode,
    input  logic [PRE_W-1:0]  cfg_prescale,
    input  logic [CYC_W-1:0]  cfg_cycle,
    input  logic              run,
    input  logic              stop_req,
    input  logic              rs_req,
    output logic              scl_o,
    output logic              tick_start_su,
    output logic              tick_start_hd,
    output logic              tick_data_su,
    output logic              tick_data_hd,
    output logic              tick_scl_rise,
    output logic              tick_scl_fall,
    output logic              tick_stop_su,
    output logic              tick_release,
    output logic [31:0]       fs_word1,
    output logic [31:0]       fs_word2,
    output logic [31:0]       fs_word3,
    output logic [31:0]       hs_word1,
    output logic [31:0]       hs_word2,
    output logic [31:0]       hs_word3,
    output logic [31:0]       hold_word
);

    tset_t            calc_set, fs_set, hs_set, act_set;
    logic [FLD_W-1:0] calc_hold, hold_f;
    logic             unit;

    i2c_tmg_calc #(.CYC_W(CYC_W), .PRE_W(PRE_W)) u_calc (
        .cycle_i (cfg_cycle),
        .pre_i   (cfg_prescale),
        .set_o   (calc_set),
        .hold_o  (calc_hold)
    );

    i2c_tmg_bank #(.NSETS(2)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (cfg_load),
        .sel_hs_i    (hs_mode),
        .calc_i      (calc_set),
        .calc_hold_i (calc_hold),
        .fs_o        (fs_set),
        .hs_o        (hs_set),
        .act_o       (act_set),
        .hold_o      (hold_f)
    );

    i2c_tmg_prescale u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .pre_i  (act_set.pre),
        .unit_o (unit)
    );

    i2c_tmg_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .unit_i     (unit),
        .run_i      (run),
        .stop_req_i (stop_req),
        .rs_req_i   (rs_req),
        .act_i      (act_set),
        .hold_i     (hold_f),
        .scl_o      (scl_o),
        .t_ssu_o    (tick_start_su),
        .t_shd_o    (tick_start_hd),
        .t_dsu_o    (tick_data_su),
        .t_dhd_o    (tick_data_hd),
        .t_rise_o   (tick_scl_rise),
        .t_fall_o   (tick_scl_fall),
        .t_stop_o   (tick_stop_su),
        .t_rel_o    (tick_release)
    );

    assign fs_word1  = pack_w1(fs_set);
    assign fs_word2  = pack_w2(fs_set);
    assign fs_word3  = pack_w3(fs_set);
    assign hs_word1  = pack_w1(hs_set);
    assign hs_word2  = pack_w2(hs_set);
    assign hs_word3  = pack_w3(hs_set);
    assign hold_word = {24'h0, hold_f};

endmodule

// File: tb/i2c_scl_timing_test.sv
`timescale 1ns/1ps
module i2c_scl_timing_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 1'b0, hs_mode = 1'b0, run = 1'b0, stop_req = 1'b0, rs_req = 1'b0;
    logic [7:0] cfg_prescale = '0, cfg_cycle = '0;
    logic scl_o, t_ssu, t_shd, t_dsu, t_dhd, t_rise, t_fall, t_stop, t_rel;
    logic [31:0] fs1, fs2, fs3, hs1, hs2, hs3, hw;

    int nchk = 0;
    int nerr = 0;
    int wd = 0;

    always #2 clk = ~clk;

    i2c_scl_timing uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .hs_mode(hs_mode),
        .cfg_prescale(cfg_prescale), .cfg_cycle(cfg_cycle), .run(run),
        .stop_req(stop_req), .rs_req(rs_req), .scl_o(scl_o),
        .tick_start_su(t_ssu), .tick_start_hd(t_shd), .tick_data_su(t_dsu),
        .tick_data_hd(t_dhd), .tick_scl_rise(t_rise), .tick_scl_fall(t_fall),
        .tick_stop_su(t_stop), .tick_release(t_rel),
        .fs_word1(fs1), .fs_word2(fs2), .fs_word3(fs3),
        .hs_word1(hs1), .hs_word2(hs2), .hs_word3(hs3), .hold_word(hw)
    );

    // ---------------- reference model ----------------
    // phases: 0 idle, 1 start setup, 2 start hold, 3 low, 4 high, 5 stop, 6 release
    int m_pc = 0, m_ph = 0, m_rem = 0, m_hold = 0;
    int m_pre [2] = '{0, 0};
    int m_cyc [2] = '{0, 0};

    function automatic int atl1(int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int plen(int ph, int c);
        int lo;
        lo = c / 2;
        if (ph == 6) return atl1(c);
        return atl1(lo);
    endfunction

    function automatic logic [31:0] ew1(int c);
        int lo; lo = c / 2;
        return (lo << 24) | (lo << 16) | (lo << 8);
    endfunction
    function automatic logic [31:0] ew2(int c);
        int lo; lo = c / 2;
        return ((lo / 2) << 24) | (lo << 8) | lo;
    endfunction
    function automatic logic [31:0] ew3(int c, int p);
        return (p << 16) | c;
    endfunction

    always @(posedge clk) begin
        int a, nx;
        bit u;
        if (!rst_n) begin
            m_pc = 0; m_ph = 0; m_rem = 0; m_hold = 0;
            m_pre = '{0, 0}; m_cyc = '{0, 0};
        end else begin
            a = hs_mode ? 1 : 0;
            u = (m_pc >= m_pre[a]);
            m_pc = u ? 0 : m_pc + 1;
            if (u) begin
                if (m_ph == 0) begin
                    if (run) begin m_ph = 1; m_rem = plen(1, m_cyc[a]); end
                end else if (m_rem <= 1) begin
                    case (m_ph)
                        1: nx = 2;
                        2: nx = 3;
                        3: nx = stop_req ? 5 : (rs_req ? 6 : 4);
                        4: nx = 3;
                        5: nx = 0;
                        default: nx = 1;
                    endcase
                    m_ph = nx;
                    m_rem = (nx == 0) ? 0 : plen(nx, m_cyc[a]);
                end else begin
                    m_rem = m_rem - 1;
                end
            end
            if (cfg_load) begin
                m_pre[a] = cfg_prescale;
                m_cyc[a] = cfg_cycle;
                m_hold = (cfg_cycle / 2) / 2;
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        int a, c, lo;
        bit u, last;
        logic [7:0] et, at;
        if (rst_n) begin
            a = hs_mode ? 1 : 0;
            c = m_cyc[a];
            lo = c / 2;
            u = (m_pc >= m_pre[a]);
            last = u && (m_ph != 0) && (m_rem <= 1);
            et[7] = u && (m_ph == 3) && (m_rem == (lo / 2) + 1);
            et[6] = u && (m_ph == 3) && ((atl1(lo) - m_rem) == m_hold);
            et[5] = last && (m_ph == 1);
            et[4] = last && (m_ph == 2);
            et[3] = last && (m_ph == 3);
            et[2] = last && (m_ph == 2 || m_ph == 4);
            et[1] = last && (m_ph == 5);
            et[0] = last && (m_ph == 6);
            at = {t_dsu, t_dhd, t_ssu, t_shd, t_rise, t_fall, t_stop, t_rel};
            nchk++;
            if (scl_o !== (m_ph != 3)) begin
                nerr++;
                $display("FAIL R6/R7 scl: actual %0b expected %0b at %0t", scl_o, (m_ph != 3), $time);
            end
            nchk++;
            if (at !== et) begin
                nerr++;
                $display("FAIL R8/R9/R4/R5 ticks: actual %b expected %b at %0t", at, et, $time);
            end
            nchk++;
            if ({fs1, fs2, fs3} !== {ew1(m_cyc[0]), ew2(m_cyc[0]), ew3(m_cyc[0], m_pre[0])} ||
                {hs1, hs2, hs3} !== {ew1(m_cyc[1]), ew2(m_cyc[1]), ew3(m_cyc[1], m_pre[1])} ||
                hw !== 32'(m_hold)) begin
                nerr++;
                $display("FAIL R1/R2/R3 words: actual %h %h %h %h %h %h %h expected cyc %0d/%0d pre %0d/%0d hold %0d",
                         fs1, fs2, fs3, hs1, hs2, hs3, hw, m_cyc[0], m_cyc[1], m_pre[0], m_pre[1], m_hold);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(bit hs, int pre, int cyc);
        hs_mode = hs; cfg_prescale = 8'(pre); cfg_cycle = 8'(cyc); cfg_load = 1'b1;
        step(1);
        cfg_load = 1'b0;
    endtask

    // clocks between two consecutive SCL-fall strobes
    task automatic fall_gap(output int gap);
        int n;
        n = 0;
        do begin @(negedge clk); n++; end while (!t_fall && n < 2000);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!t_fall && gap < 2000);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int gap, nrel, nstop, bad;
        step(3);
        @(negedge clk);
        // R10 reset state
        chk("R10 scl", 32'(scl_o), 32'd1);
        chk("R10 ticks", 32'({t_ssu, t_shd, t_dsu, t_dhd, t_rise, t_fall, t_stop, t_rel}), 32'd0);
        chk("R10 fs1", fs1, 32'd0);
        chk("R10 hold", hw, 32'd0);
        rst_n = 1'b1;
        step(2);

        // R1 R2 fast set: prescale 1, cycle 10
        load(1'b0, 1, 10);
        @(negedge clk);
        chk("R1/R2 fs_word1", fs1, 32'h0505_0500);
        chk("R1/R2 fs_word2", fs2, 32'h0200_0505);
        chk("R1/R2 fs_word3", fs3, 32'h0001_000A);
        chk("R1 hold", hw, 32'h0000_0002);
        // R3 high-speed set: prescale 0, cycle 6; fast set untouched
        load(1'b1, 0, 6);
        @(negedge clk);
        chk("R3 hs_word1", hs1, 32'h0303_0300);
        chk("R3 hs_word2", hs2, 32'h0100_0303);
        chk("R3 hs_word3", hs3, 32'h0000_0006);
        chk("R3 fs kept", fs1, 32'h0505_0500);
        chk("R3 hold shared", hw, 32'h0000_0001);

        // R6 run in fast mode, then stop
        hs_mode = 1'b0; step(1);
        run = 1'b1; step(40);
        fall_gap(gap);
        chk("R4/R5 fast low+high clocks", 32'(gap), 32'd20);
        run = 1'b0; stop_req = 1'b1;
        step(60);
        stop_req = 1'b0;

        // R7 high-speed run with repeated start, stop wins when both set
        hs_mode = 1'b1; step(1);
        run = 1'b1; step(25);
        rs_req = 1'b1; step(30);
        rs_req = 1'b0; step(20);
        stop_req = 1'b1; rs_req = 1'b1; run = 1'b0;
        nrel = 0; nstop = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (t_stop) nstop++;
            if (t_rel && nstop == 0) nrel++;
        end
        chk("R7 stop seen", 32'(nstop), 32'd1);
        chk("R7 stop priority", 32'(nrel), 32'd0);
        // R11 idle ignores requests
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!scl_o || t_ssu || t_rel || t_stop || t_fall || t_rise) bad++;
        end
        chk("R11 idle quiet", 32'(bad), 32'd0);
        step(1);
        stop_req = 1'b0; rs_req = 1'b0;

        // R5 zero-length phases: prescale 2, cycle 0
        hs_mode = 1'b0; step(1);
        load(1'b0, 2, 0);
        run = 1'b1;
        fall_gap(gap);
        chk("R5 zero phases low+high clocks", 32'(gap), 32'd6);
        load(1'b0, 2, 1);
        step(12);
        fall_gap(gap);
        chk("R5 cycle 1 low+high clocks", 32'(gap), 32'd6);
        run = 1'b0; stop_req = 1'b1; step(30); stop_req = 1'b0;

        // R1 longest phases: prescale 0, cycle 255
        load(1'b1, 0, 255);
        run = 1'b1;
        fall_gap(gap);
        chk("R1/R4 cycle 255 low+high clocks", 32'(gap), 32'd254);
        run = 1'b0; stop_req = 1'b1; step(300); stop_req = 1'b0;
        step(5);
        finish_run();
    end

endmodule